// File: doc/BRIEF.md
# Single-Wire Bus Line Monitor

This block sits beside the receive path of a slave on a single-wire, open-drain bus. The bus idles high. The block samples the line through a synchronizer and measures how long each low period lasts, counting microsecond ticks from an external timebase. Short lows are data slots and produce no output. A low that outlasts the reset threshold is reported as a bus reset when the line returns high. A low that lasts for the sleep timeout produces a pulse that resets the I/O bit and, if sleep is enabled, a sleep request.

The speed-select input chooses the reset threshold: 120 µs at standard speed, or 16 µs in overdrive. The block captures this input when each low period begins, so a change during a low does not affect that low. A single saturating counter times both the reset window and the sleep window. The sleep window defaults to 2 s, expressed in ticks.

Top module: `owire_line_mon`

## Requirements
- R1: The bus input passes through SYNC_STAGES (default 2) flops. With `tick_us` high on every cycle, `reset_det` goes high on the third rising clock edge after `bus_in` returns high, and it is low after the first two of those edges.
- R2: With `speed_ovd` = 0 (standard), a low period of N counted ticks produces a reset pulse exactly when N > STD_RST_US.
- R3: With `speed_ovd` = 1 (overdrive), a low period of N counted ticks produces a reset pulse exactly when N > OVD_RST_US.
- R4: The block captures `speed_ovd` when the synchronized line first samples low. A change of `speed_ovd` during the low period has no effect on the threshold applied to that period.
- R5: `reset_det` is a one-cycle pulse. It fires at most once per low period, on the sample where the line returns high.
- R6: The low counter advances only on cycles with `tick_us` = 1. A low of any length with no ticks gives no reset pulse and no long-low pulse.
- R7: `io_reset` pulses for one cycle, once per low period, when the count reaches SLEEP_US. It does this regardless of `sleep_en`.
- R8: `sleep_req` is high while the count is at SLEEP_US and `sleep_en` = 1. It is never high when `sleep_en` = 0. It drops one cycle after the line samples high.
- R9: The counter saturates at SLEEP_US and never wraps. It clears on any high sample, so each low period is timed from zero.
- R10: While `rst_n` is low, and right after it, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 1 | Raw sampled level of the bus line |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| speed_ovd | input | 1 | Speed select: 0 = standard, 1 = overdrive |
| sleep_en | input | 1 | Allows a long low to request sleep |
| reset_det | output | 1 | One-cycle pulse when a qualifying reset low ends |
| sleep_req | output | 1 | Sleep request after a full-length low while enabled |
| io_reset | output | 1 | One-cycle pulse when a low reaches the sleep length |

## Verification
The assertions check on every cycle:
- the counter bound and the clear-on-high behaviour;
- the single-cycle width of both pulses;
- that the captured speed holds steady through a low;
- that a long-low pulse with sleep enabled is always accompanied by a sleep request.

Only the bench's scenarios can show which lengths qualify. It sweeps every low length across both speeds and both sleep-enable values, and places the expected outcome on each side of each threshold. It also shows the exact synchronizer latency, that a mid-low speed change is ignored, and that a tickless low never qualifies.

// File: rtl/owlm_pkg.sv
package owlm_pkg;
   typedef enum logic {SPD_STD = 1'b0, SPD_OVD = 1'b1} speed_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/owlm_sync.sv
module owlm_sync #(
   parameter int unsigned STAGES = 2,
   parameter logic        IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         initial $error("owlm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/owlm_low_timer.sv
module owlm_low_timer #(
   parameter int unsigned LIMIT = 2000000,
   parameter int unsigned W     = 21
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         line,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic         sat,
   output logic         reach
);
   localparam logic [W-1:0] LIM_V = W'(LIMIT);
   localparam logic [W-1:0] PRE_V = W'(LIMIT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         reach <= 1'b0;
      end else begin
         reach <= 1'b0;
         if (line) begin
            cnt <= '0;
         end else if (tick && cnt != LIM_V) begin
            cnt   <= cnt + 1'b1;
            reach <= (cnt == PRE_V);
         end
      end
   end

   assign sat = (cnt == LIM_V);

   // R9: bounded, never wraps past the limit
   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM_V);
   // R9: a high sample clears the count
   assert_clear_on_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      line |=> (cnt == '0));
   // R7: long-low pulse lasts one cycle
   assert_io_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reach |=> !reach);
   // R6: no tick, no advance
   assert_tick_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !line) |=> $stable(cnt));
endmodule

// File: rtl/owlm_classify.sv
module owlm_classify #(
   parameter int unsigned STD_RST = 120,
   parameter int unsigned OVD_RST = 16,
   parameter int unsigned W       = 21
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         line,
   input  logic         speed,
   input  logic [W-1:0] cnt,
   output logic         reset_det
);
   import owlm_pkg::*;

   localparam logic [W-1:0] STD_V = W'(STD_RST);
   localparam logic [W-1:0] OVD_V = W'(OVD_RST);

   logic         prev;
   speed_e       spd_lat;
   logic [W-1:0] thr;
   logic         rise, fall;

   assign rise = line & ~prev;
   assign fall = ~line & prev;

   generate
      if (STD_RST == OVD_RST) begin : g_single_thr
         assign thr = STD_V;
      end else begin : g_dual_thr
         assign thr = (spd_lat == SPD_OVD) ? OVD_V : STD_V;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev      <= 1'b1;
         spd_lat   <= SPD_STD;
         reset_det <= 1'b0;
      end else begin
         prev      <= line;
         if (fall) spd_lat <= speed_e'(speed);
         reset_det <= rise && (cnt > thr);
      end
   end

   // R5: reset indication is a single-cycle pulse
   assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reset_det |=> !reset_det);
   // R4: captured speed holds for the whole low period
   assert_speed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!line && !fall) |=> $stable(spd_lat));
   // R5: a pulse only follows a low-to-high transition
   assert_rst_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reset_det |-> prev);
endmodule

// File: rtl/owire_line_mon.sv
module owire_line_mon #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STD_RST_US  = 120,
   parameter int unsigned OVD_RST_US  = 16,
   parameter int unsigned SLEEP_US    = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_in,
   input  logic tick_us,
   input  logic speed_ovd,
   input  logic sleep_en,
   output logic reset_det,
   output logic sleep_req,
   output logic io_reset
);
   import owlm_pkg::*;

   localparam int unsigned CW = cnt_width(SLEEP_US);

   generate
      if (!(OVD_RST_US <= STD_RST_US && STD_RST_US < SLEEP_US)) begin : g_bad_thr
         initial $error("owire_line_mon: thresholds must satisfy OVD <= STD < SLEEP");
      end
   endgenerate

   logic          line_s;
   logic [CW-1:0] low_cnt;
   logic          low_sat;
   logic          low_reach;

   owlm_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line_s)
   );

   owlm_low_timer #(.LIMIT(SLEEP_US), .W(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .line(line_s), .tick(tick_us),
      .cnt(low_cnt), .sat(low_sat), .reach(low_reach)
   );

   owlm_classify #(.STD_RST(STD_RST_US), .OVD_RST(OVD_RST_US), .W(CW)) u_class (
      .clk(clk), .rst_n(rst_n), .line(line_s), .speed(speed_ovd),
      .cnt(low_cnt), .reset_det(reset_det)
   );

   assign io_reset  = low_reach;
   assign sleep_req = low_sat & sleep_en;

   // R8: an enabled long low always raises the sleep request
   assert_sleep_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_reset && sleep_en) |-> sleep_req);
   // R8: sleep request drops after the line returns high
   assert_sleep_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_s |=> !sleep_req);
   // R10: outputs quiet during reset
   always_comb begin
      if (!rst_n) begin
         assert_quiet_reset_R10: assert (!reset_det && !io_reset);
      end
   end
endmodule

// File: tb/owire_line_mon_tb.sv
module owire_line_mon_tb;
   localparam int STD = 12;
   localparam int OVD = 4;
   localparam int SLP = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_in = 1'b1;
   logic tick_us = 1'b1;
   logic speed_ovd = 1'b0;
   logic sleep_en = 1'b0;
   logic reset_det, sleep_req, io_reset;

   int n_chk = 0;
   int n_bad = 0;
   int rst_seen = 0;
   int io_seen = 0;
   int slp_seen = 0;

   always #4 clk = ~clk;

   owire_line_mon #(.SYNC_STAGES(2), .STD_RST_US(STD), .OVD_RST_US(OVD),
                    .SLEEP_US(SLP)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .tick_us(tick_us),
      .speed_ovd(speed_ovd), .sleep_en(sleep_en),
      .reset_det(reset_det), .sleep_req(sleep_req), .io_reset(io_reset)
   );

   always @(negedge clk) begin
      if (reset_det) rst_seen++;
      if (io_reset)  io_seen++;
      if (sleep_req) slp_seen++;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic low_trial(input int len, input logic spd, input logic en,
                            input logic tk, input logic flip);
      @(negedge clk); #1;
      rst_seen = 0; io_seen = 0; slp_seen = 0;
      speed_ovd = spd; sleep_en = en; tick_us = tk;
      bus_in = 1'b0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (flip && i == 3) speed_ovd = ~spd;
      end
      bus_in = 1'b1;
      repeat (6) @(negedge clk);
      tick_us = 1'b1;
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset_det", int'(reset_det), 0);
      check("R10 io_reset", int'(io_reset), 0);
      check("R10 sleep_req", int'(sleep_req), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 post-reset quiet", rst_seen + io_seen + slp_seen, 0);

      // R2 R3 R7 R8 R9: sweep every length, speed and sleep enable
      for (int s = 0; s < 2; s++)
         for (int e = 0; e < 2; e++)
            for (int len = 1; len <= SLP + 6; len++) begin
               int thr;
               thr = (s == 1) ? OVD : STD;
               low_trial(len, logic'(s), logic'(e), 1'b1, 1'b0);
               check(s ? "R3 reset" : "R2 reset", rst_seen, (len > thr) ? 1 : 0);
               check("R7 io_reset", io_seen, (len >= SLP) ? 1 : 0);
               check("R8 sleep_req", (slp_seen > 0) ? 1 : 0,
                     (len >= SLP && e == 1) ? 1 : 0);
            end

      // R9: after a saturating low, a short low is timed afresh
      low_trial(SLP + 10, 1'b0, 1'b0, 1'b1, 1'b0);
      low_trial(STD, 1'b0, 1'b0, 1'b1, 1'b0);
      check("R9 fresh count", rst_seen, 0);

      // R4: speed flip during the low is ignored
      low_trial(8, 1'b1, 1'b0, 1'b1, 1'b1);
      check("R4 ovd kept", rst_seen, 1);
      low_trial(8, 1'b0, 1'b0, 1'b1, 1'b1);
      check("R4 std kept", rst_seen, 0);

      // R6: no ticks, nothing qualifies
      low_trial(SLP + 20, 1'b0, 1'b1, 1'b0, 1'b0);
      check("R6 no reset", rst_seen, 0);
      check("R6 no io", io_seen, 0);

      // R1 R5: exact latency from line release to pulse
      @(negedge clk);
      speed_ovd = 1'b0; tick_us = 1'b1;
      bus_in = 1'b0;
      repeat (20) @(negedge clk);
      bus_in = 1'b1;
      @(negedge clk); check("R1 edge1", int'(reset_det), 0);
      @(negedge clk); check("R1 edge2", int'(reset_det), 0);
      @(negedge clk); check("R1 edge3", int'(reset_det), 1);
      @(negedge clk); check("R5 one cycle", int'(reset_det), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule